// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block is a timekeeping core. It samples the level of a 32.768 kHz oscillator and counts its rising edges in a binary prescaler. Each time the prescaler wraps, the block makes one calendar update: seconds, minutes, hours, day of week, date, month, year and a century bit all advance, and all of them are held in packed BCD. The hour field works in either 24-hour or 12-hour form. The date wraps according to the length of each month, and February follows a leap rule that treats every year divisible by four as a leap year. A one-cycle pulse marks each update, so alarm logic further along can sample the fields on that pulse.

Software loads any field through a single-cycle register write port. The same port controls a halt bit for the oscillator and a rate select for a square-wave output that is taken from the prescaler taps. An oscillator-stop flag is set at reset and whenever the counter is halted. It stays set until software clears it.

Register addresses on the write port: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month (bit 7 is the century bit), 6 year, 7 control (bit 0 is the halt bit, bits 2:1 are the rate select), 8 status (bit 0 is the stop flag).

Top module: `bcd_calendar_core`

## Requirements
- R1: After reset the fields read 00:00:00 in 24-hour form, day of week 01, date 01, month 01 with the century bit at 0, and year 00. The stop flag reads 1, the halt bit is 0 and the rate select is 11.
- R2: Seconds and minutes count in BCD from 00 to 59. The step after 59 is 00, and that step carries into the next field.
- R3: When hour bit 6 is 0 (24-hour form), hours count in BCD from 00 to 23, with 09 going to 10 and 19 going to 20. The step from 23 to 00 advances the day.
- R4: When hour bit 6 is 1 (12-hour form), bit 5 is the PM bit and bits 4:0 hold 01 to 12 in BCD. The sequence runs 11 → 12 → 01. The PM bit toggles on the step into 12. Only the step from 11 PM to 12 AM advances the day.
- R5: The day of week advances once per day and wraps from 7 back to 1.
- R6: The date wraps to 01 after the last day of its month and carries into the month: 30 days for months 04, 06, 09 and 11; 31 days for the other months; in month 02, 29 days when the BCD year is divisible by four and 28 days otherwise.
- R7: The month wraps from 12 to 01 and carries into the year. The year wraps from 99 to 00 and toggles month bit 7.
- R8: An update happens on every 2^DIV_W-th rising edge of the oscillator level. `sec_pulse` is high for exactly the one cycle in which the new field values first appear.
- R9: A write to address 0 clears the prescaler. The next update follows a full 2^DIV_W edges later, and the divider's top bit rises 2^(DIV_W-1) edges after the write.
- R10: `sqw_o` follows the rate select: 00 gives the divider top bit (1 Hz), 01 gives divider bit 2, 10 gives divider bit 1, and 11 gives the registered oscillator level.
- R11: While the halt bit is 1, no edge is counted, no update happens, `sqw_o` is 0 and the stop flag is set.
- R12: The stop flag clears only when 0 is written to status bit 0 while the block is not halted. Writing 1 to that bit has no effect.
- R13: A field write stores only the defined bits: seconds and minutes 6:0, hours 6:0, day of week 2:0, date 5:0, month 7 and 4:0, year 7:0. All other bits read 0. An update that falls in the same cycle as a field write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xtal_lvl | input | 1 | Sampled oscillator level, counted on its rising edges |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 4 | Register address for the write |
| wr_data | input | 8 | Register write data |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hours with the mode bit and the PM/tens bit |
| dow_o | output | 8 | Day of week, 1 to 7 |
| date_o | output | 8 | Date of the month, BCD |
| month_o | output | 8 | Month, BCD, with the century bit in bit 7 |
| year_o | output | 8 | Year, BCD |
| stop_flag | output | 1 | Oscillator-stop flag |
| sqw_o | output | 1 | Square-wave output |
| sec_pulse | output | 1 | One-cycle pulse on each calendar update |

## Verification
The bench builds the block with DIV_W = 4, so one second lasts 16 oscillator edges, or 64 clocks. Every rollover chain, from seconds up through the century bit, therefore finishes in a few hundred cycles. At this width divider bits 2, 1 and the top bit are all distinct, which keeps every rate select observable in short count windows. The time from a seconds write to the first update also stays small enough to measure exactly.

// File: rtl/bcd_calendar_core.sv
module bcd_calendar_core #(
  parameter int DIV_W = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       xtal_lvl,
  input  logic       wr_en,
  input  logic [3:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] dow_o,
  output logic [7:0] date_o,
  output logic [7:0] month_o,
  output logic [7:0] year_o,
  output logic       stop_flag,
  output logic       sqw_o,
  output logic       sec_pulse
);
  localparam logic [DIV_W-1:0] DIV_LAST = '1;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : v + 8'd1;
  endfunction

  logic             xq, osc_off_q;
  logic [1:0]       rate_q;
  logic [DIV_W-1:0] div_q;
  logic             edge_w, wr_time, tick;
  logic [7:0]       hr_nxt, last_day;
  logic [4:0]       ysum, mon_inc, hr12_inc;
  logic             day_c, leap, tap;

  assign edge_w  = xtal_lvl & ~xq & ~osc_off_q;
  assign wr_time = wr_en && (wr_addr < 4'd7);
  assign tick    = edge_w && (div_q == DIV_LAST) && !wr_time;

  assign ysum     = {year_o[7:4], 1'b0} + {1'b0, year_o[3:0]};
  assign leap     = (ysum[1:0] == 2'b00);
  assign mon_inc  = (month_o[3:0] == 4'd9) ? 5'h10 : {month_o[4], month_o[3:0] + 4'd1};
  assign hr12_inc = (hour_o[3:0] == 4'd9) ? 5'h10 : {hour_o[4], hour_o[3:0] + 4'd1};

  always_comb begin
    case (month_o[4:0])
      5'h02:                      last_day = leap ? 8'h29 : 8'h28;
      5'h04, 5'h06, 5'h09, 5'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase
  end

  always_comb begin
    hr_nxt = hour_o;
    day_c  = 1'b0;
    if (hour_o[6]) begin
      if (hour_o[4:0] == 5'h11) begin
        hr_nxt = {2'b01, ~hour_o[5], 5'h12};
        day_c  = hour_o[5];
      end else if (hour_o[4:0] == 5'h12) begin
        hr_nxt = {2'b01, hour_o[5], 5'h01};
      end else begin
        hr_nxt = {2'b01, hour_o[5], hr12_inc};
      end
    end else if (hour_o[5:0] == 6'h23) begin
      hr_nxt = 8'h00;
      day_c  = 1'b1;
    end else begin
      hr_nxt = bcd_inc(hour_o);
    end
  end

  always_comb begin
    case (rate_q)
      2'b00:   tap = div_q[DIV_W-1];
      2'b01:   tap = div_q[2];
      2'b10:   tap = div_q[1];
      default: tap = xq;
    endcase
  end
  assign sqw_o = tap & ~osc_off_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xq        <= 1'b0;
      osc_off_q <= 1'b0;
      rate_q    <= 2'b11;
      div_q     <= '0;
      stop_flag <= 1'b1;
      sec_pulse <= 1'b0;
      sec_o     <= 8'h00;
      min_o     <= 8'h00;
      hour_o    <= 8'h00;
      dow_o     <= 8'h01;
      date_o    <= 8'h01;
      month_o   <= 8'h01;
      year_o    <= 8'h00;
    end else begin
      xq        <= xtal_lvl;
      sec_pulse <= tick;

      if (wr_en && wr_addr == 4'd0) div_q <= '0;
      else if (edge_w)              div_q <= div_q + DIV_W'(1);

      if (osc_off_q)                                        stop_flag <= 1'b1;
      else if (wr_en && wr_addr == 4'd8 && !wr_data[0])     stop_flag <= 1'b0;

      if (wr_en) begin
        case (wr_addr)
          4'd0: sec_o   <= {1'b0, wr_data[6:0]};
          4'd1: min_o   <= {1'b0, wr_data[6:0]};
          4'd2: hour_o  <= {1'b0, wr_data[6:0]};
          4'd3: dow_o   <= {5'b0, wr_data[2:0]};
          4'd4: date_o  <= {2'b0, wr_data[5:0]};
          4'd5: month_o <= {wr_data[7], 2'b0, wr_data[4:0]};
          4'd6: year_o  <= wr_data;
          4'd7: begin
            osc_off_q <= wr_data[0];
            rate_q    <= wr_data[2:1];
          end
          default: ;
        endcase
      end

      if (tick) begin
        sec_o <= (sec_o == 8'h59) ? 8'h00 : bcd_inc(sec_o);
        if (sec_o == 8'h59) begin
          min_o <= (min_o == 8'h59) ? 8'h00 : bcd_inc(min_o);
          if (min_o == 8'h59) begin
            hour_o <= hr_nxt;
            if (day_c) begin
              dow_o <= (dow_o == 8'h07) ? 8'h01 : dow_o + 8'd1;
              if (date_o == last_day) begin
                date_o <= 8'h01;
                if (month_o[4:0] == 5'h12) begin
                  month_o <= {month_o[7] ^ (year_o == 8'h99), 7'h01};
                  year_o  <= (year_o == 8'h99) ? 8'h00 : bcd_inc(year_o);
                end else begin
                  month_o <= {month_o[7], 2'b00, mon_inc};
                end
              end else begin
                date_o <= bcd_inc(date_o);
              end
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/bcd_calendar_core_chk.sv
module bcd_calendar_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [3:0] wr_addr,
  input logic [7:0] wr_data,
  input logic [7:0] sec_o,
  input logic [7:0] month_o,
  input logic       stop_flag,
  input logic       sqw_o,
  input logic       sec_pulse,
  input logic       osc_off_q
);
  assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pulse |=> !sec_pulse);

  assert_sec_moves_on_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sec_o) && !$past(wr_en)) |-> sec_pulse);

  assert_halt_no_update_R11: assert property (@(posedge clk) disable iff (!rst_n)
    osc_off_q |=> !sec_pulse);

  assert_halt_sqw_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    osc_off_q |-> !sqw_o);

  assert_halt_sets_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    osc_off_q |=> stop_flag);

  assert_flag_clear_by_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stop_flag) |-> ($past(wr_en) && $past(wr_addr) == 4'd8 && !$past(wr_data[0])));

  assert_month_write_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 4'd5) |=> (month_o == ($past(wr_data) & 8'h9F)));
endmodule

bind bcd_calendar_core bcd_calendar_core_chk u_chk (.*);

// File: tb/test_bcd_calendar_core.sv
module test_bcd_calendar_core;
  localparam int W = 4;
  localparam int DIVN = 1 << W;

  logic       clk = 0, rst_n = 0, xtal = 0, wr_en = 0;
  logic [3:0] wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o;
  logic       stop_flag, sqw_o, sec_pulse;

  int n_tests = 0, n_fail = 0;
  bit running = 0;

  bcd_calendar_core #(.DIV_W(W)) i_bcd_calendar_core (
    .clk(clk), .rst_n(rst_n), .xtal_lvl(xtal), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .dow_o(dow_o),
    .date_o(date_o), .month_o(month_o), .year_o(year_o), .stop_flag(stop_flag),
    .sqw_o(sqw_o), .sec_pulse(sec_pulse));

  always #5 clk = ~clk;

  function automatic int b2i(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction
  function automatic logic [7:0] i2b(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction
  function automatic int mlen(input int mo, input int yr);
    if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  int m_sec, m_min, m_h, m_pm, m_12, m_dow, m_date, m_mon, m_cent, m_year;
  int m_div, m_x, m_off, m_rate, m_flag, m_pulse;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sec = 0; m_min = 0; m_h = 0; m_pm = 0; m_12 = 0; m_dow = 1; m_date = 1;
      m_mon = 1; m_cent = 0; m_year = 0; m_div = 0; m_x = 0; m_off = 0;
      m_rate = 3; m_flag = 1; m_pulse = 0;
    end else begin
      bit edge_s, wrt, tk, dayc;
      edge_s = xtal && (m_x == 0) && (m_off == 0);
      wrt = wr_en && (wr_addr < 7);
      tk = edge_s && (m_div == DIVN - 1) && !wrt;
      if (m_off != 0) m_flag = 1;
      else if (wr_en && wr_addr == 8 && !wr_data[0]) m_flag = 0;
      if (wr_en && wr_addr == 0) m_div = 0;
      else if (edge_s) m_div = (m_div + 1) % DIVN;
      if (wr_en) begin
        case (wr_addr)
          0: m_sec = b2i(wr_data & 8'h7F);
          1: m_min = b2i(wr_data & 8'h7F);
          2: begin
            m_12 = int'(wr_data[6]);
            if (wr_data[6]) begin m_pm = int'(wr_data[5]); m_h = b2i(wr_data & 8'h1F); end
            else begin m_pm = 0; m_h = b2i(wr_data & 8'h3F); end
          end
          3: m_dow = int'(wr_data[2:0]);
          4: m_date = b2i(wr_data & 8'h3F);
          5: begin m_cent = int'(wr_data[7]); m_mon = b2i(wr_data & 8'h1F); end
          6: m_year = b2i(wr_data);
          7: begin m_off = int'(wr_data[0]); m_rate = int'(wr_data[2:1]); end
          default: ;
        endcase
      end
      if (tk) begin
        dayc = 0;
        m_sec++;
        if (m_sec == 60) begin
          m_sec = 0; m_min++;
          if (m_min == 60) begin
            m_min = 0;
            if (m_12 != 0) begin
              if (m_h == 11) begin m_h = 12; m_pm = 1 - m_pm; dayc = (m_pm == 0); end
              else if (m_h == 12) m_h = 1;
              else m_h++;
            end else begin
              m_h++;
              if (m_h == 24) begin m_h = 0; dayc = 1; end
            end
          end
        end
        if (dayc) begin
          m_dow = (m_dow == 7) ? 1 : m_dow + 1;
          m_date++;
          if (m_date > mlen(m_mon, m_year)) begin
            m_date = 1; m_mon++;
            if (m_mon == 13) begin
              m_mon = 1; m_year++;
              if (m_year == 100) begin m_year = 0; m_cent = 1 - m_cent; end
            end
          end
        end
      end
      m_x = int'(xtal);
      m_pulse = int'(tk);
    end
  end

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      if (n_fail < 40) $display("FAIL %s at %0t: got %h expected %h", tag, $time, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (running && rst_n) begin
      logic [7:0] eh, es;
      eh = (m_12 != 0) ? (8'h40 | 8'(m_pm << 5) | i2b(m_h)) : i2b(m_h);
      case (m_rate)
        0: es = 8'((m_div >> (W - 1)) & 1);
        1: es = 8'((m_div >> 2) & 1);
        2: es = 8'((m_div >> 1) & 1);
        default: es = 8'(m_x);
      endcase
      if (m_off != 0) es = 0;
      chk("R2 model sec", sec_o, i2b(m_sec));
      chk("R2 model min", min_o, i2b(m_min));
      chk("R3 model hour", hour_o, eh);
      chk("R5 model dow", dow_o, 8'(m_dow));
      chk("R6 model date", date_o, i2b(m_date));
      chk("R7 model month", month_o, 8'(m_cent << 7) | i2b(m_mon));
      chk("R7 model year", year_o, i2b(m_year));
      chk("R12 model flag", {7'b0, stop_flag}, 8'(m_flag));
      chk("R10 model sqw", {7'b0, sqw_o}, es);
      chk("R8 model pulse", {7'b0, sec_pulse}, 8'(m_pulse));
    end
  end

  initial begin
    forever begin
      repeat (2) @(negedge clk);
      xtal = ~xtal;
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic set_time(input logic [7:0] yr, input logic [7:0] mo, input logic [7:0] dt,
                          input logic [7:0] dw, input logic [7:0] hr, input logic [7:0] mn,
                          input logic [7:0] sc);
    wr(6, yr); wr(5, mo); wr(4, dt); wr(3, dw); wr(2, hr); wr(1, mn); wr(0, sc);
  endtask

  task automatic wait_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      do @(negedge clk); while (!sec_pulse);
    end
  endtask

  task automatic count_rises(input int len, output int rises);
    logic prev;
    rises = 0;
    @(negedge clk);
    prev = sqw_o;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (sqw_o && !prev) rises++;
      prev = sqw_o;
    end
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int t0, t1, t2, r;
    repeat (4) @(negedge clk);
    rst_n = 1;
    running = 1;
    @(negedge clk);
    // R1 reset values
    chk("R1 sec", sec_o, 8'h00);
    chk("R1 hour", hour_o, 8'h00);
    chk("R1 dow", dow_o, 8'h01);
    chk("R1 date", date_o, 8'h01);
    chk("R1 month", month_o, 8'h01);
    chk("R1 flag", {7'b0, stop_flag}, 8'h01);

    // R12 clear and write-one
    wr(8, 8'h00);
    chk("R12 cleared", {7'b0, stop_flag}, 8'h00);
    wr(8, 8'h01);
    chk("R12 write one ignored", {7'b0, stop_flag}, 8'h00);

    // R13 masked writes
    wr(0, 8'hD9);
    chk("R13 sec mask", sec_o, 8'h59);
    wr(3, 8'hF3);
    chk("R13 dow mask", dow_o, 8'h03);

    // R2 R3 R5 R6 non-leap February into March at midnight
    set_time(8'h23, 8'h02, 8'h28, 8'h07, 8'h23, 8'h59, 8'h58);
    wait_pulses(1);
    chk("R2 sec 59", sec_o, 8'h59);
    wait_pulses(1);
    chk("R2 sec wrap", sec_o, 8'h00);
    chk("R2 min wrap", min_o, 8'h00);
    chk("R3 hour 23->00", hour_o, 8'h00);
    chk("R5 dow 7->1", dow_o, 8'h01);
    chk("R6 feb28 nonleap", date_o, 8'h01);
    chk("R6 month 03", month_o, 8'h03);

    // R6 leap February
    set_time(8'h24, 8'h02, 8'h28, 8'h02, 8'h23, 8'h59, 8'h59);
    wait_pulses(1);
    chk("R6 leap 29", date_o, 8'h29);
    set_time(8'h24, 8'h02, 8'h29, 8'h02, 8'h23, 8'h59, 8'h59);
    wait_pulses(1);
    chk("R6 leap wrap", date_o, 8'h01);
    chk("R6 leap month", month_o, 8'h03);
    set_time(8'h00, 8'h04, 8'h30, 8'h02, 8'h23, 8'h59, 8'h59);
    wait_pulses(1);
    chk("R6 30-day month", month_o, 8'h05);
    set_time(8'h00, 8'h01, 8'h31, 8'h02, 8'h23, 8'h59, 8'h59);
    wait_pulses(1);
    chk("R6 31-day month", month_o, 8'h02);
    chk("R6 31-day date", date_o, 8'h01);

    // R7 century
    set_time(8'h99, 8'h12, 8'h31, 8'h05, 8'h23, 8'h59, 8'h59);
    wait_pulses(1);
    chk("R7 century month", month_o, 8'h81);
    chk("R7 year wrap", year_o, 8'h00);

    // R3 tens digit
    set_time(8'h10, 8'h06, 8'h15, 8'h03, 8'h09, 8'h59, 8'h59);
    wait_pulses(1);
    chk("R3 09->10", hour_o, 8'h10);
    set_time(8'h10, 8'h06, 8'h15, 8'h03, 8'h19, 8'h59, 8'h59);
    wait_pulses(1);
    chk("R3 19->20", hour_o, 8'h20);

    // R4 12-hour
    set_time(8'h10, 8'h06, 8'h15, 8'h03, 8'h51, 8'h59, 8'h59);
    wait_pulses(1);
    chk("R4 11AM->12PM", hour_o, 8'h72);
    chk("R4 no day step", date_o, 8'h15);
    set_time(8'h10, 8'h06, 8'h15, 8'h03, 8'h72, 8'h59, 8'h59);
    wait_pulses(1);
    chk("R4 12PM->1PM", hour_o, 8'h61);
    set_time(8'h10, 8'h06, 8'h10, 8'h03, 8'h71, 8'h59, 8'h59);
    wait_pulses(1);
    chk("R4 11PM->12AM", hour_o, 8'h52);
    chk("R4 day step dow", dow_o, 8'h04);
    chk("R4 day step date", date_o, 8'h11);

    // R8 update spacing and R9 divider clear
    wr(7, 8'h00);
    wait_pulses(1);
    t0 = int'($time / 10);
    wait_pulses(1);
    t1 = int'($time / 10);
    chk("R8 period", 8'(t1 - t0), 8'(DIVN * 4));
    wr(0, 8'h10);
    t0 = int'($time / 10);
    do @(negedge clk); while (!sqw_o);
    t1 = int'($time / 10);
    wait_pulses(1);
    t2 = int'($time / 10);
    chk("R9 half then full", 8'(t2 - t1), 8'(DIVN * 2));
    chk("R9 full after write", {7'b0, (t2 - t0) <= DIVN * 4 + 4 && (t2 - t0) > DIVN * 4 - 4}, 8'h01);
    chk("R9 sec after write", sec_o, 8'h11);

    // R10 rate taps
    wr(7, 8'h02);
    count_rises(128, r);
    chk("R10 rate 01", 8'(r), 8'd4);
    wr(7, 8'h04);
    count_rises(128, r);
    chk("R10 rate 10", 8'(r), 8'd8);
    wr(7, 8'h06);
    count_rises(128, r);
    chk("R10 rate 11", 8'(r), 8'd32);

    // R11 halt
    wr(7, 8'h07);
    t0 = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (sec_pulse || sqw_o) t0++;
    end
    chk("R11 no pulse no sqw", 8'(t0), 8'h00);
    chk("R11 flag set", {7'b0, stop_flag}, 8'h01);
    wr(8, 8'h00);
    chk("R12 stays while halted", {7'b0, stop_flag}, 8'h01);
    wr(7, 8'h06);
    wr(8, 8'h00);
    chk("R12 clear after resume", {7'b0, stop_flag}, 8'h00);
    t0 = b2i(sec_o);
    wait_pulses(1);
    chk("R11 resumes counting", sec_o, i2b((t0 + 1) % 60));

    repeat (4) @(negedge clk);
    running = 0;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule